// File: doc/BRIEF.md
# Serial port interrupt flag controller

This block holds the interrupt side of a serial port. Software sees it through a small synchronous register bus. A control register carries two interrupt enables. A mode register carries a two-bit prescaler clock select. A status register holds five event flags: transmit buffer empty, receive buffer full, overrun, framing error and parity error.

The transmitter and receiver datapaths raise the flags with one-cycle set pulses. Software can drop a flag only through a guarded sequence. It must first read the status register while that flag shows 1, and then write 0 to the flag's bit. A stray write of 0 therefore cannot lose an event that software has not yet seen.

Three level-sensitive, registered request lines come out of the block: transmit, receive and error. The receive and error requests share one enable.

Top module: `sio_irq_ctl`

## Requirements
- R1: After reset, the control register reads 0x00 and the mode register reads 0x00. The status register reads 0x80 (only transmit-empty set), `cksel` is 0 and all three request outputs are 0.
- R2: Control register (address 0) bit 7 is the transmit enable and bit 6 is the receive/error enable. Both can be read and written; all other control bits read 0.
- R3: Mode register (address 1) bits 1:0 hold the clock select driven on `cksel`. The values 0, 1, 2 and 3 ask the prescaler for base clock divided by 1, 4, 16 and 64. Other mode bits read 0, and `cksel` changes only on a mode write.
- R4: `tx_irq` is 1 exactly when, one cycle earlier, the transmit enable and the transmit-empty flag were both 1.
- R5: `rx_irq` is 1 exactly when, one cycle earlier, the receive enable and the receive-full flag were both 1.
- R6: `err_irq` is 1 exactly when, one cycle earlier, the receive enable was 1 and at least one of the overrun, framing or parity flags was 1.
- R7: Status register (address 2) holds the flags at bits 7 (transmit empty), 6 (receive full), 5 (overrun), 4 (framing) and 3 (parity). A flag clears when a 0 is written to its bit after a status read that returned that bit as 1. A 0 written to a flag that was not read as 1 leaves it set, and each flag tracks its own read.
- R8: Writing 1 to a status bit has no effect. Flags are set only by the set pulse inputs.
- R9: When a set pulse and a qualifying clear land in the same cycle, the flag stays set. A later 0 write does not clear it until the flag has been read as 1 again.
- R10: Clearing an enable withdraws the matching request while the flag stays set.
- R11: A status read that returns a flag as 0 does not authorise a clear of that flag once it is later set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| tx_empty_set | input | 1 | Transmit buffer empty event pulse |
| rx_full_set | input | 1 | Receive buffer full event pulse |
| overrun_set | input | 1 | Overrun event pulse |
| framing_set | input | 1 | Framing error event pulse |
| parity_set | input | 1 | Parity error event pulse |
| cksel | output | 2 | Prescaler clock select |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench sweeps every combination of the five flags against all four enable settings. This catches an error request that ignores one of its three sources, or a request that takes the wrong enable.

The guarded-clear cases are targeted one by one:
- A 0 write with no prior read. A design that skipped the guard would drop the flag and the request with it.
- A read that saw the flag as 0. A design that armed on any read would clear an event software never saw.
- A set pulse colliding with the clear. A design that let the clear win would lose the new event.
- Two flags where only one was read as 1. A design with one shared arm bit would clear both.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NFLAG    = 5;
  localparam int FL_TXE   = 0;
  localparam int FL_RXF   = 1;
  localparam int FL_OVR   = 2;
  localparam int FL_FRM   = 3;
  localparam int FL_PAR   = 4;

  localparam int STAT_TOP = 7;
  localparam int TXIE_POS = 7;
  localparam int RXIE_POS = 6;
  localparam int CKS_W    = 2;

  typedef struct packed {
    logic tx_ie;
    logic rx_ie;
  } irq_en_t;

  // status bit position of flag index idx: flags fill downward from the top bit
  function automatic int stat_pos(input int idx);
    return STAT_TOP - idx;
  endfunction

  // only the transmit-empty flag leaves reset set
  function automatic logic flag_rst(input int idx);
    return (idx == FL_TXE);
  endfunction

endpackage

// File: rtl/sio_bus_dec.sv
module sio_bus_dec
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_CTRL = 0,
  parameter int ADDR_MODE = 1,
  parameter int ADDR_STAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] ctrl_view,
  input  logic [DATA_W-1:0] mode_view,
  input  logic [DATA_W-1:0] stat_view,
  output logic              ctrl_wr,
  output logic              mode_wr,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rdata
);

  logic              hit_ctrl;
  logic              hit_mode;
  logic              hit_stat;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = (addr == ADDR_W'(ADDR_CTRL));
  assign hit_mode = (addr == ADDR_W'(ADDR_MODE));
  assign hit_stat = (addr == ADDR_W'(ADDR_STAT));

  assign ctrl_wr  = we & hit_ctrl;
  assign mode_wr  = we & hit_mode;
  assign stat_wr  = we & hit_stat;
  assign stat_rd  = re & hit_stat;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = ctrl_view;
    else if (hit_mode) rd_mux = mode_view;
    else if (hit_stat) rd_mux = stat_view;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              mode_wr,
  input  logic              wr_txie,
  input  logic              wr_rxie,
  input  logic [CKS_W-1:0]  wr_cks,
  output irq_en_t           en,
  output logic [CKS_W-1:0]  cksel,
  output logic [DATA_W-1:0] ctrl_view,
  output logic [DATA_W-1:0] mode_view
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      cksel <= '0;
    end else begin
      if (ctrl_wr) begin
        en.tx_ie <= wr_txie;
        en.rx_ie <= wr_rxie;
      end
      if (mode_wr) cksel <= wr_cks;
    end
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[TXIE_POS] = en.tx_ie;
    ctrl_view[RXIE_POS] = en.rx_ie;
    mode_view           = '0;
    mode_view[CKS_W-1:0] = cksel;
  end

endmodule

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic rd_hit,
  input  logic clr_req,
  output logic flag,
  output logic arm,
  output logic clr_fire
);

  // clear only honoured when armed and not overtaken by a set
  assign clr_fire = clr_req & arm & ~set_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= RST_VAL;
      arm  <= 1'b0;
    end else if (set_p) begin
      flag <= 1'b1;
      arm  <= 1'b0;
    end else if (clr_fire) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (rd_hit && flag) begin
      arm  <= 1'b1;
    end
  end

endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  irq_en_t          en,
  input  logic [NFLAG-1:0] flags,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             err_irq
);

  logic tx_want;
  logic rx_want;
  logic err_any;
  logic err_want;

  assign tx_want  = en.tx_ie & flags[FL_TXE];
  assign rx_want  = en.rx_ie & flags[FL_RXF];
  assign err_any  = flags[FL_OVR] | flags[FL_FRM] | flags[FL_PAR];
  assign err_want = en.rx_ie & err_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      tx_irq  <= tx_want;
      rx_irq  <= rx_want;
      err_irq <= err_want;
    end
  end

endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_CTRL = 0,
  parameter int ADDR_MODE = 1,
  parameter int ADDR_STAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_empty_set,
  input  logic              rx_full_set,
  input  logic              overrun_set,
  input  logic              framing_set,
  input  logic              parity_set,
  output logic [1:0]        cksel,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              err_irq
);

  logic              ctrl_wr;
  logic              mode_wr;
  logic              stat_wr;
  logic              stat_rd;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] mode_view;
  logic [DATA_W-1:0] stat_view;
  irq_en_t           en;
  logic              tx_ie;
  logic              rx_ie;
  logic [NFLAG-1:0]  set_vec;
  logic [NFLAG-1:0]  clr_req;
  logic [NFLAG-1:0]  clr_fire;
  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  arms;
  logic              unused_wbits;

  assign set_vec      = {parity_set, framing_set, overrun_set, rx_full_set, tx_empty_set};
  assign tx_ie        = en.tx_ie;
  assign rx_ie        = en.rx_ie;
  assign unused_wbits = ^bus_wdata;

  sio_bus_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_MODE(ADDR_MODE), .ADDR_STAT(ADDR_STAT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .ctrl_view(ctrl_view), .mode_view(mode_view), .stat_view(stat_view),
    .ctrl_wr(ctrl_wr), .mode_wr(mode_wr), .stat_wr(stat_wr), .stat_rd(stat_rd),
    .rdata(bus_rdata)
  );

  sio_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode_wr(mode_wr),
    .wr_txie(bus_wdata[TXIE_POS]), .wr_rxie(bus_wdata[RXIE_POS]),
    .wr_cks(bus_wdata[CKS_W-1:0]),
    .en(en), .cksel(cksel), .ctrl_view(ctrl_view), .mode_view(mode_view)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign clr_req[g] = stat_wr & ~bus_wdata[stat_pos(g)];
    sio_flag_cell #(.RST_VAL(flag_rst(g))) u_cell (
      .clk(clk), .rst_n(rst_n), .set_p(set_vec[g]), .rd_hit(stat_rd),
      .clr_req(clr_req[g]), .flag(flags[g]), .arm(arms[g]),
      .clr_fire(clr_fire[g])
    );
  end

  always_comb begin
    stat_view = '0;
    for (int i = 0; i < NFLAG; i++) stat_view[stat_pos(i)] = flags[i];
  end

  sio_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .en(en), .flags(flags),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
  );

endmodule

// File: rtl/sio_irq_ctl_chk.sv
module sio_irq_ctl_chk
  import sio_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en_tx,
  input logic             en_rx,
  input logic [NFLAG-1:0] set_vec,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] arms,
  input logic [NFLAG-1:0] clr_fire,
  input logic             mode_wr,
  input logic [1:0]       cksel,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             err_irq
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_fl
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> (flags[g] && !arms[g]));
    assert_hold_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !arms[g]) |=> flags[g]);
    assert_clear_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire[g] |=> !flags[g]);
    assert_no_self_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[g] && !set_vec[g]) |=> !flags[g]);
  end

  assert_tx_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tx && flags[FL_TXE]) |=> tx_irq);
  assert_tx_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_tx && flags[FL_TXE]) |=> !tx_irq);
  assert_rx_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx && flags[FL_RXF]) |=> rx_irq);
  assert_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_rx && flags[FL_RXF]) |=> !rx_irq);
  assert_err_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx && (flags[FL_OVR] || flags[FL_FRM] || flags[FL_PAR])) |=> err_irq);
  assert_err_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_rx && (flags[FL_OVR] || flags[FL_FRM] || flags[FL_PAR])) |=> !err_irq);
  assert_cks_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(cksel));

endmodule

bind sio_irq_ctl sio_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_tx(tx_ie), .en_rx(rx_ie),
  .set_vec(set_vec), .flags(flags), .arms(arms), .clr_fire(clr_fire),
  .mode_wr(mode_wr), .cksel(cksel),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/sio_irq_ctl_tb.sv
module sio_irq_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] sets = '0;
  logic [1:0] cksel;
  logic       tx_irq, rx_irq, err_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty_set(sets[0]), .rx_full_set(sets[1]), .overrun_set(sets[2]),
    .framing_set(sets[3]), .parity_set(sets[4]),
    .cksel(cksel), .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // flag index i appears at status bit 7-i
  function automatic logic [7:0] stat_of(input logic [4:0] p);
    return {p[0], p[1], p[2], p[3], p[4], 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic fire(input logic [4:0] p);
    @(negedge clk);
    sets = p;
    @(negedge clk);
    sets = '0;
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic clear_all;
    logic [7:0] d;
    do_read(A_STAT, d);
    do_write(A_STAT, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irqs", {5'b0, tx_irq, rx_irq, err_irq}, 8'h00);
    chk("R1 cksel", {6'b0, cksel}, 8'h00);
    do_read(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
    do_read(A_MODE, d); chk("R1 mode", d, 8'h00);
    do_read(A_STAT, d); chk("R1 stat", d, 8'h80);

    // R2 enable bits only
    do_write(A_CTRL, 8'hFF); do_read(A_CTRL, d); chk("R2 ctrl ff", d, 8'hC0);
    do_write(A_CTRL, 8'h3F); do_read(A_CTRL, d); chk("R2 ctrl 3f", d, 8'h00);
    do_write(A_CTRL, 8'h80); do_read(A_CTRL, d); chk("R2 ctrl 80", d, 8'h80);

    // R3 clock select sweep; divisor is 4**cs
    for (int cs = 0; cs < 4; cs++) begin
      do_write(A_MODE, {6'b101011, 2'(cs)});
      chk($sformatf("R3 cksel div%0d", 1 << (2 * cs)), {6'b0, cksel}, 8'(cs));
      do_read(A_MODE, d);
      chk("R3 mode readback", d, 8'(cs));
      do_write(A_CTRL, 8'h00);
      chk("R3 cksel held", {6'b0, cksel}, 8'(cs));
    end

    // R4 R5 R6 sweep over all flag patterns and enables
    for (int p = 0; p < 32; p++) begin
      for (int e = 0; e < 4; e++) begin
        logic [4:0] pv;
        logic [1:0] ev;
        pv = 5'(p);
        ev = 2'(e);
        clear_all;
        fire(pv);
        do_write(A_CTRL, {ev[1], ev[0], 6'b0});
        settle;
        chk("R4 tx_irq", {7'b0, tx_irq}, {7'b0, ev[1] & pv[0]});
        chk("R5 rx_irq", {7'b0, rx_irq}, {7'b0, ev[0] & pv[1]});
        chk("R6 err_irq", {7'b0, err_irq}, {7'b0, ev[0] & (pv[2] | pv[3] | pv[4])});
        do_read(A_STAT, d);
        chk("R8 stat pattern", d, stat_of(pv));
      end
    end

    // R7 unread zero write keeps the flag
    clear_all;
    do_write(A_CTRL, 8'h40);
    fire(5'b00010);
    do_write(A_STAT, 8'h00);
    settle;
    chk("R7 unread clear ignored", {7'b0, rx_irq}, 8'h01);
    do_read(A_STAT, d); chk("R7 stat armed read", d, 8'h40);
    do_write(A_STAT, 8'h00);
    settle;
    chk("R7 cleared irq", {7'b0, rx_irq}, 8'h00);
    do_read(A_STAT, d); chk("R7 cleared stat", d, 8'h00);

    // R7 arm is per flag
    fire(5'b00100);
    do_read(A_STAT, d); chk("R7 overrun seen", d, 8'h20);
    fire(5'b01000);
    do_write(A_STAT, 8'h00);
    do_read(A_STAT, d); chk("R7 framing kept", d, 8'h10);

    // R8 writing ones neither clears nor sets
    do_write(A_STAT, 8'hFF);
    do_read(A_STAT, d); chk("R8 ones no effect", d, 8'h10);
    do_write(A_STAT, 8'h00);
    do_read(A_STAT, d); chk("R8 then cleared", d, 8'h00);

    // R9 set beats clear, arm dropped
    fire(5'b10000);
    do_read(A_STAT, d); chk("R9 parity seen", d, 8'h08);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 8'h00; bus_we = 1'b1; sets = 5'b10000;
    @(negedge clk);
    bus_we = 1'b0; sets = '0;
    settle;
    chk("R9 set wins", {7'b0, err_irq}, 8'h01);
    do_write(A_STAT, 8'h00);
    settle;
    chk("R9 arm dropped", {7'b0, err_irq}, 8'h01);
    clear_all;
    settle;
    chk("R9 reread clears", {7'b0, err_irq}, 8'h00);

    // R10 disabling withdraws request, flag stays
    fire(5'b00011);
    do_write(A_CTRL, 8'hC0);
    settle;
    chk("R10 both up", {6'b0, tx_irq, rx_irq}, 8'h03);
    do_write(A_CTRL, 8'h00);
    settle;
    chk("R10 withdrawn", {6'b0, tx_irq, rx_irq}, 8'h00);
    do_read(A_STAT, d); chk("R10 flags stay", d, 8'hC0);

    // R11 read of a zero flag does not arm it
    clear_all;
    do_write(A_CTRL, 8'h40);
    do_read(A_STAT, d); chk("R11 empty read", d, 8'h00);
    fire(5'b00010);
    do_write(A_STAT, 8'h00);
    settle;
    chk("R11 flag survives", {7'b0, rx_irq}, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule